// File: doc/BRIEF.md
# Register Save/Restore-All Sequencer

This unit copies the eight general registers onto a byte-addressed, flat, downward-growing stack with one command, or copies them back. The command is a start pulse with an 8-bit opcode and a size flag. Opcode 0x60 saves and opcode 0x61 restores. The size flag picks 32-bit slots (a 32-byte frame) or 16-bit slots (a 16-byte frame).

The unit reads the register file through a combinational read port and writes it through a byte-masked write port. It makes one memory access per cycle and never waits for memory. The stack pointer is a separate input. The unit takes a copy of it when it accepts a command and writes the new value back once, in the final cycle, together with a one-cycle done pulse.

Register index numbering is fixed: 0=A, 1=C, 2=D, 3=B, 4=SP, 5=BP, 6=SI, 7=DI. Frame slot k (k = 0..7, rising address) holds register 7-k. Slot 3 is therefore the stack pointer slot.

Top module: `regstack_seq`

## Requirements
- R1: A start pulse seen while idle begins a save when opcode_i is 0x60 and a restore when opcode_i is 0x61. Any other opcode is ignored: busy_o stays low, no access is made and the stack pointer is unchanged.
- R2: A 32-bit save (size32_i=1) writes 8 words, one per cycle, at addresses SP-32+4k for k = 0..7. Slot k holds register 7-k, mem_be_o is 4'b1111 and the data sits in lanes [31:0].
- R3: A 16-bit save (size32_i=0) writes 8 halfwords at SP-16+2k with mem_be_o = 4'b0011. The value sits in mem_wdata_o[15:0], the upper half is zero, and no byte outside the 16-byte frame changes.
- R4: The stack pointer slot (slot 3) receives the stack pointer as it was when the command was accepted, truncated to 16 bits in 16-bit mode.
- R5: A restore reads slot k at SP+k*stride and writes register 7-k. It makes no memory access and no register write in the slot-3 cycle, so register 4 is never loaded.
- R6: A 16-bit restore writes with rf_wbe_o = 4'b0011, so the upper 16 bits of each restored register keep their old value. A 32-bit restore uses 4'b1111.
- R7: The new stack pointer is SP-frame after a save and SP+frame after a restore, where frame is 32 or 16. sp_we_o is asserted exactly once per command, in the done cycle.
- R8: Timing is fixed. busy_o rises in the cycle after the accepting edge and stays high for 9 cycles: 8 slot cycles followed by the done cycle. done_o is high for exactly one cycle, the last busy cycle.
- R9: Start pulses that arrive while busy_o is high are ignored and have no effect on the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe |
| opcode_i | input | 8 | 0x60 save, 0x61 restore |
| size32_i | input | 1 | 1: 32-bit slots, 0: 16-bit slots |
| sp_i | input | ADDR_W | Current stack pointer |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | ADDR_W | New stack pointer |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | DATA_W | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | DATA_W | Register file write data |
| rf_wbe_o | output | DATA_W/8 | Register file byte write enables |
| mem_en_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_be_o | output | DATA_W/8 | Byte lanes, lane 0 at mem_addr_o (little-endian) |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, same cycle |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Final cycle pulse |

## Verification
A slot counter that is off by one shows up at once in the address sequence and the register index. That skews the whole frame, which a word-by-word compare after each command catches. A latched mode bit or stack pointer that is wrong appears in the first access address and in the final stack pointer value. The skipped restore slot shows up as register 4 changing or as one access too many. Sequencing faults (an accepted start while busy, an early or repeated done) change the busy length or the done count, which the bench measures each cycle.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

  localparam logic [7:0] OPC_SAVE    = 8'h60;
  localparam logic [7:0] OPC_RESTORE = 8'h61;
  localparam int         NUM_SLOTS   = 8;
  localparam logic [2:0] SP_SLOT     = 3'd3;
  localparam logic [2:0] LAST_SLOT   = 3'(NUM_SLOTS - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // Frame slot k holds register (7 - k).
  function automatic logic [2:0] slot_reg(input logic [2:0] k);
    return LAST_SLOT - k;
  endfunction

  // Byte offset of slot k inside the frame.
  function automatic logic [5:0] slot_offset(input logic [2:0] k, input logic wide);
    return wide ? {1'b0, k, 2'b00} : {2'b00, k, 1'b0};
  endfunction

  function automatic logic [5:0] frame_bytes(input logic wide);
    return wide ? 6'd32 : 6'd16;
  endfunction

endpackage

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
  import regstack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] opcode_i,
  input  logic       size32_i,
  output logic       accept_o,
  output logic       run_o,
  output logic       fin_o,
  output logic [2:0] slot_o,
  output logic       pop_o,
  output logic       wide_o
);
  seq_state_e st_q;
  logic [2:0] slot_q;
  logic       pop_q, wide_q;
  logic       opc_ok;

  assign opc_ok   = (opcode_i == OPC_SAVE) || (opcode_i == OPC_RESTORE);
  assign accept_o = (st_q == ST_IDLE) && start_i && opc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      pop_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          st_q   <= ST_RUN;
          slot_q <= '0;
          pop_q  <= (opcode_i == OPC_RESTORE);
          wide_q <= size32_i;
        end
        ST_RUN: begin
          slot_q <= slot_q + 3'd1;
          if (slot_q == LAST_SLOT) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_FIN);
  assign slot_o = slot_q;
  assign pop_o  = pop_q;
  assign wide_o = wide_q;

  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o); // R8
  AST_FIN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> $past(run_o) && $past(slot_o) == LAST_SLOT); // R8
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && start_i) |=> (run_o || fin_o)); // R9
  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> run_o && slot_o == 3'd0); // R8

endmodule

// File: rtl/regstack_agen.sv
module regstack_agen
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] sp_base_i,
  input  logic              pop_i,
  input  logic              wide_i,
  input  logic [2:0]        slot_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  logic [ADDR_W-1:0] frame_w, offs_w, base_w;

  assign frame_w   = ADDR_W'(frame_bytes(wide_i));
  assign offs_w    = ADDR_W'(slot_offset(slot_i, wide_i));
  assign base_w    = pop_i ? sp_base_i : (sp_base_i - frame_w);
  assign addr_o    = base_w + offs_w;
  assign sp_next_o = pop_i ? (sp_base_i + frame_w) : (sp_base_i - frame_w);

endmodule

// File: rtl/regstack_dpath.sv
module regstack_dpath
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  run_i,
  input  logic                  pop_i,
  input  logic                  wide_i,
  input  logic [2:0]            slot_i,
  input  logic [ADDR_W-1:0]     sp_base_i,
  input  logic [DATA_W-1:0]     rf_rdata_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic [2:0]            rf_idx_o,
  output logic                  rf_we_o,
  output logic [DATA_W-1:0]     rf_wdata_o,
  output logic [DATA_W/8-1:0]   rf_wbe_o,
  output logic                  mem_en_o,
  output logic                  mem_we_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic [DATA_W/8-1:0]   mem_be_o
);
  localparam int BE_W   = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int HALF_B = BE_W / 2;

  logic               skip_slot;
  logic [DATA_W-1:0]  store_val, half_mask;
  logic [BE_W-1:0]    lane_mask;

  assign skip_slot = (slot_i == SP_SLOT);
  assign rf_idx_o  = slot_reg(slot_i);
  assign half_mask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign lane_mask = wide_i ? {BE_W{1'b1}} : {{(BE_W-HALF_B){1'b0}}, {HALF_B{1'b1}}};

  assign store_val   = skip_slot ? DATA_W'(sp_base_i) : rf_rdata_i;
  assign mem_wdata_o = wide_i ? store_val : (store_val & half_mask);
  assign mem_be_o    = lane_mask;
  assign mem_en_o    = run_i && !(pop_i && skip_slot);
  assign mem_we_o    = run_i && !pop_i;

  assign rf_we_o    = run_i && pop_i && !skip_slot;
  assign rf_wdata_o = wide_i ? mem_rdata_i : (mem_rdata_i & half_mask);
  assign rf_wbe_o   = lane_mask;

endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
  import regstack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [7:0]          opcode_i,
  input  logic                size32_i,
  input  logic [ADDR_W-1:0]   sp_i,
  output logic                sp_we_o,
  output logic [ADDR_W-1:0]   sp_wdata_o,
  output logic [2:0]          rf_raddr_o,
  input  logic [DATA_W-1:0]   rf_rdata_i,
  output logic                rf_we_o,
  output logic [2:0]          rf_waddr_o,
  output logic [DATA_W-1:0]   rf_wdata_o,
  output logic [DATA_W/8-1:0] rf_wbe_o,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                done_o
);
  logic              accept, run, fin, pop, wide;
  logic [2:0]        slot, rf_idx;
  logic [ADDR_W-1:0] sp_q, sp_next;

  regstack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .size32_i(size32_i), .accept_o(accept), .run_o(run), .fin_o(fin),
    .slot_o(slot), .pop_o(pop), .wide_o(wide)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (accept) sp_q <= sp_i;
  end

  regstack_agen #(.ADDR_W(ADDR_W)) u_agen (
    .sp_base_i(sp_q), .pop_i(pop), .wide_i(wide), .slot_i(slot),
    .addr_o(mem_addr_o), .sp_next_o(sp_next)
  );

  regstack_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .run_i(run), .pop_i(pop), .wide_i(wide), .slot_i(slot), .sp_base_i(sp_q),
    .rf_rdata_i(rf_rdata_i), .mem_rdata_i(mem_rdata_i), .rf_idx_o(rf_idx),
    .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .rf_wbe_o(rf_wbe_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o)
  );

  assign rf_raddr_o = rf_idx;
  assign rf_waddr_o = rf_idx;
  assign sp_we_o    = fin;
  assign sp_wdata_o = sp_next;
  assign busy_o     = run || fin;
  assign done_o     = fin;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && $past(mem_en_o)) |->
      (mem_addr_o - $past(mem_addr_o)) == (wide ? ADDR_W'(4) : ADDR_W'(2))); // R2
  AST_SP_NOT_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> rf_waddr_o != 3'd4); // R5
  AST_NO_RF_WRITE_ON_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !rf_we_o); // R5
  AST_SP_WE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we_o |=> !sp_we_o && !busy_o); // R7
  AST_SP_WE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we_o |-> $past(busy_o) && !mem_en_o); // R7
  AST_SP_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(sp_q)); // R4

endmodule

// File: tb/regstack_seq_tb.sv
module regstack_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        size32_i = 1'b1;
  logic [31:0] sp_q = 32'h0;
  logic        sp_we_o;
  logic [31:0] sp_wdata_o;
  logic [2:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o;
  logic [3:0]  rf_wbe_o, mem_be_o;
  logic        rf_we_o, mem_en_o, mem_we_o, busy_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  logic [31:0] rf [8];
  logic [7:0]  mem [256];
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regstack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .size32_i(size32_i), .sp_i(sp_q), .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .rf_wbe_o(rf_wbe_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  assign rf_rdata_i  = rf[rf_raddr_o];
  assign mem_rdata_i = {mem[8'(mem_addr_o + 32'd3)], mem[8'(mem_addr_o + 32'd2)],
                        mem[8'(mem_addr_o + 32'd1)], mem[mem_addr_o[7:0]]};

  always @(posedge clk) begin
    if (sp_we_o) sp_q <= sp_wdata_o;
    if (rf_we_o)
      for (int b = 0; b < 4; b++)
        if (rf_wbe_o[b]) rf[rf_waddr_o][8*b +: 8] <= rf_wdata_o[8*b +: 8];
    if (mem_en_o && mem_we_o)
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[8'(mem_addr_o + 32'(b))] <= mem_wdata_o[8*b +: 8];
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [7:0] a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
  endfunction

  function automatic logic [15:0] rd16(input logic [7:0] a);
    return {mem[8'(a+1)], mem[a]};
  endfunction

  // Issue one command; count busy cycles, done pulses, writes and reads.
  // inject_at > 0 raises a second start (restore) during that busy cycle.
  task automatic run_op(input logic [7:0] op, input logic w32, input int inject_at,
                        output int nbusy, output int ndone, output int done_at,
                        output int nwr, output int nrd);
    nbusy = 0; ndone = 0; done_at = -1; nwr = 0; nrd = 0;
    @(negedge clk);
    start_i = 1'b1; opcode_i = op; size32_i = w32;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!busy_o) break;
      nbusy++;
      if (done_o) begin ndone++; done_at = nbusy; end
      if (mem_en_o && mem_we_o) nwr++;
      if (mem_en_o && !mem_we_o) nrd++;
      start_i = (nbusy == inject_at);
      opcode_i = 8'h61;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  logic [31:0] orig [8];

  task automatic t_reset();
    chk(!busy_o && !done_o && !mem_en_o && !sp_we_o && !rf_we_o, "R8 reset idle",
        {27'd0, busy_o, done_o, mem_en_o, sp_we_o, rf_we_o}, 32'd0);
  endtask

  task automatic t_push32();
    int nb, nd, da, nw, nr;
    for (int i = 0; i < 8; i++) begin rf[i] = 32'h1000_0001 * (i + 1); orig[i] = rf[i]; end
    sp_q = 32'h0000_0080;
    run_op(8'h60, 1'b1, 0, nb, nd, da, nw, nr);
    chk(nb == 9, "R8 busy length", 32'(nb), 32'd9);
    chk(nd == 1 && da == 9, "R8 done in last busy cycle", 32'(da), 32'd9);
    chk(nw == 8 && nr == 0, "R2 eight writes", 32'(nw), 32'd8);
    for (int k = 0; k < 8; k++) begin
      if (k == 3) chk(rd32(8'h6C) == 32'h80, "R4 saved stack pointer", rd32(8'h6C), 32'h80);
      else chk(rd32(8'(8'h60 + 4*k)) == orig[7-k], "R2 slot content",
               rd32(8'(8'h60 + 4*k)), orig[7-k]);
    end
    chk(sp_q == 32'h60, "R7 save lowers SP by 32", sp_q, 32'h60);
  endtask

  task automatic t_pop32();
    int nb, nd, da, nw, nr;
    for (int i = 0; i < 8; i++) rf[i] = 32'hFFFF_FFFF;
    rf[4] = 32'h0000_CAFE;
    run_op(8'h61, 1'b1, 0, nb, nd, da, nw, nr);
    chk(nr == 7 && nw == 0, "R5 seven reads, slot 3 skipped", 32'(nr), 32'd7);
    for (int i = 0; i < 8; i++)
      if (i != 4) chk(rf[i] == orig[i], "R5 restored register", rf[i], orig[i]);
    chk(rf[4] == 32'hCAFE, "R5 register 4 untouched", rf[4], 32'hCAFE);
    chk(sp_q == 32'h80, "R7 restore raises SP by 32", sp_q, 32'h80);
  endtask

  task automatic t_push16();
    int nb, nd, da, nw, nr;
    for (int i = 0; i < 8; i++) begin rf[i] = 32'hA5A5_0000 | (32'h0101 * (i + 3)); orig[i] = rf[i]; end
    mem[8'hA0] = 8'h5A; mem[8'h8F] = 8'h3C;
    sp_q = 32'h1234_00A0;
    run_op(8'h60, 1'b0, 0, nb, nd, da, nw, nr);
    chk(nw == 8 && nb == 9, "R3 eight halfword writes", 32'(nw), 32'd8);
    for (int k = 0; k < 8; k++) begin
      if (k == 3) chk(rd16(8'h96) == 16'h00A0, "R4 saved low SP", 32'(rd16(8'h96)), 32'h00A0);
      else chk(rd16(8'(8'h90 + 2*k)) == orig[7-k][15:0], "R3 halfword slot",
               32'(rd16(8'(8'h90 + 2*k))), 32'(orig[7-k][15:0]));
    end
    chk(mem[8'hA0] == 8'h5A && mem[8'h8F] == 8'h3C, "R3 bytes outside frame kept",
        {16'd0, mem[8'hA0], mem[8'h8F]}, 32'h5A3C);
    chk(sp_q == 32'h1234_0090, "R7 save lowers SP by 16", sp_q, 32'h1234_0090);
  endtask

  task automatic t_pop16();
    int nb, nd, da, nw, nr;
    for (int i = 0; i < 8; i++) rf[i] = 32'hBEEF_0000 + 32'(i);
    run_op(8'h61, 1'b0, 0, nb, nd, da, nw, nr);
    for (int i = 0; i < 8; i++)
      if (i != 4) chk(rf[i] == {16'hBEEF, orig[i][15:0]}, "R6 upper half kept",
                      rf[i], {16'hBEEF, orig[i][15:0]});
    chk(rf[4] == 32'hBEEF_0004, "R5 register 4 untouched 16-bit", rf[4], 32'hBEEF_0004);
    chk(sp_q == 32'h1234_00A0, "R7 restore raises SP by 16", sp_q, 32'h1234_00A0);
  endtask

  task automatic t_bad_opcode();
    int nb, nd, da, nw, nr;
    sp_q = 32'h40;
    run_op(8'h90, 1'b1, 0, nb, nd, da, nw, nr);
    repeat (2) @(negedge clk);
    chk(nb == 0 && !busy_o, "R1 unknown opcode ignored", 32'(nb), 32'd0);
    chk(sp_q == 32'h40, "R1 SP unchanged", sp_q, 32'h40);
  endtask

  task automatic t_start_busy();
    int nb, nd, da, nw, nr;
    sp_q = 32'h40;
    run_op(8'h60, 1'b1, 3, nb, nd, da, nw, nr);
    chk(nb == 9 && nd == 1, "R9 start while busy ignored", 32'(nb), 32'd9);
    chk(nw == 8 && nr == 0, "R9 running save not disturbed", 32'(nw), 32'd8);
    @(negedge clk);
    chk(!busy_o && sp_q == 32'h20, "R9 no second command", sp_q, 32'h20);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) rf[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_push32();
    t_pop32();
    t_push16();
    t_pop16();
    t_bad_opcode();
    t_start_busy();
    summary();
  end

endmodule